// File: doc/BRIEF.md
# Byte-Command I2C Bus Master

This block is a single-master I2C controller that works one byte at a time. A host gives it one command per handshake. Start opens or reopens a transfer and sends the address byte. Send writes a byte. Receive reads a byte and answers it with a chosen acknowledge level. Stop releases the bus. The block drives the two open-drain lines through output enables that pull low, and it senses the real line levels on separate inputs. Because it senses the lines, a slave can stretch the clock by holding SCL low.

The host raises `exec_req` together with exactly one command line. The block samples them on the next clock edge while `busy` is low. It then reports the shifted byte, the acknowledge it saw, whether it holds the bus, and a level flag plus a one-cycle strobe when a byte completes. A Start issued while the bus is still held produces a repeated start. All bus timing comes from an internal tick divider that counts only cycles qualified by `tick_en`. SCL spends two ticks low and two ticks high per bit.

Top module: `i2c_cmd_master`

## Requirements
- R1: Command lines are one-hot.
    - `cmd_start` produces a start condition followed by the `wr_byte` address byte.
    - `cmd_send` transmits `wr_byte`.
    - `cmd_recv` reads a byte from the slave.
    - `cmd_stop` produces a stop condition.
    - Each bus event appears exactly once, in command order.
- R2: Acceptance. When `exec_req` is high and `busy` is low, the next rising clock edge samples the command lines, `wr_byte` and `ack_out`, and `busy` goes high on that edge. While `busy` is high, further `exec_req` and command activity changes nothing on the bus.
- R3: `busy` falls on the first edge at which the command has finished and `exec_req` is low. It stays high while `exec_req` is held after the command has finished. A one-cycle `exec_req` pulse is enough to run a command.
- R4: A Start accepted while `bus_held` is high generates a repeated start: SDA is released while SCL is low, then SCL is released, then SDA falls while SCL is high.
- R5: Bus ownership and Stop.
    - `bus_held` rises when SDA falls with SCL high at a start.
    - `bus_held` falls when the stop condition completes (SDA rises with SCL high).
    - A Stop accepted while `bus_held` is low produces no bus activity and completes at once.
- R6: Data capture. Bits go out and come in most significant bit first. SDA is shifted into the byte register when the controller pulls SCL low at the end of each data bit, in both send and receive. `rd_byte` always shows that register, so after a send it holds the byte read back from the bus.
- R7: Byte completion flags.
    - `byte_done` goes high when the acknowledge slot ends, and `byte_strobe` is high for exactly one cycle at that moment.
    - `byte_done` is cleared on the edge that accepts the next command.
    - A Stop produces no strobe.
- R8: Acknowledge handling. `ack_seen` holds the SDA level sampled in the latest acknowledge slot (0 means acknowledged). In the acknowledge slot the controller drives `ack_out` for a Receive (0 pulls SDA low) and releases SDA for Start and Send.
- R9: Clock stretching. While SCL is released by the controller but sensed low, the tick divider is cleared and held. After the slave lets SCL rise, the high phase lasts the normal two ticks.
- R10: Tick timing. A tick occurs every `DIVISOR` cycles in which `tick_en` is high, so the SCL high phase of a data bit lasts 2·`DIVISOR` enabled cycles.
- R11: Reset. A synchronous active-low reset releases SDA and SCL and clears `busy`, `bus_held` and `byte_done`. This holds even in the middle of a transfer.
- R12: SDA changes only while SCL is low, apart from the edges that form start and stop conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Qualifies cycles counted by the tick divider |
| exec_req | input | 1 | Command request |
| cmd_start | input | 1 | Start (or repeated start) plus address byte |
| cmd_send | input | 1 | Send one byte |
| cmd_recv | input | 1 | Receive one byte |
| cmd_stop | input | 1 | Stop condition |
| wr_byte | input | 8 | Byte to transmit |
| ack_out | input | 1 | Acknowledge level to drive after a received byte |
| rd_byte | output | 8 | Shift register contents |
| ack_seen | output | 1 | Last sampled acknowledge level |
| bus_held | output | 1 | Bus owned between start and stop |
| byte_done | output | 1 | Byte and acknowledge completed |
| byte_strobe | output | 1 | One-cycle pulse at byte completion |
| busy | output | 1 | Command in progress or request still high |
| sda_oe | output | 1 | Pull SDA low when high |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | Pull SCL low when high |
| scl_in | input | 1 | Sensed SCL level |

## Verification
The assertions rely on the host keeping the command lines one-hot whenever `exec_req` is high. They also assume that `sda_in` and `scl_in` follow a wired-AND of the controller's enables and the slave's pulls, so a released line reads high unless the slave holds it. The bench keeps to these assumptions in two ways. It drives commands one at a time from a single task, and it computes both sensed lines combinationally from the pull-downs. Its slave model changes SDA only while SCL is low, and it stretches the clock only after the controller has pulled SCL low.

// File: rtl/i2c_cmd_pkg.sv
// Shared types for the byte-command I2C master.
// Assumes byte-wide transfers with one acknowledge slot per byte.
package i2c_cmd_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CW = $clog2(BYTE_W + 1);

    typedef enum logic [1:0] {
        OP_START,
        OP_SEND,
        OP_RECV,
        OP_STOP
    } op_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_START,
        SQ_BITS,
        SQ_STOP
    } sq_e;

endpackage

// File: rtl/i2c_tick_gen.sv
// Tick divider: emits one tick every DIVISOR enabled cycles.
// Assumes DIVISOR >= 2; clr restarts the count and suppresses the tick.
module i2c_tick_gen #(
    parameter int DIVISOR = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIVISOR > 2) ? $clog2(DIVISOR) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIVISOR - 1);

    logic [CW-1:0] cnt;

    // Tick when the enabled count reaches its last value.
    assign tick = en && !clr && (cnt == LAST);

    // Count enabled cycles; restart on clear or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_cmd_accept.sv
// Command handshake: accepts one request while idle and holds busy
// until the bus sequencer is idle and the request line is low.
// Assumes at most one command line is high with exec_req.
module i2c_cmd_accept
    import i2c_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_req,
    input  logic              cmd_start,
    input  logic              cmd_send,
    input  logic              cmd_recv,
    input  logic              cmd_stop,
    input  logic              seq_idle,
    output logic              busy,
    output logic              go,
    output op_e               go_op
);

    // Accept a request only when not busy.
    assign go = exec_req && !busy;

    // Encode the one-hot command lines.
    always_comb begin
        if (cmd_start)      go_op = OP_START;
        else if (cmd_stop)  go_op = OP_STOP;
        else if (cmd_send)  go_op = OP_SEND;
        else                go_op = OP_RECV;
    end

    // Busy rises on acceptance, falls when finished and released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (go) begin
            busy <= 1'b1;
        end else if (busy && seq_idle && !exec_req) begin
            busy <= 1'b0;
        end
    end

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_req && !busy) |=> busy);

    p_hold_while_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && exec_req) |=> busy);

    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(seq_idle) && !$past(exec_req)));

endmodule

// File: rtl/i2c_bus_seq.sv
// Bus sequencer: generates start, repeated start, byte and stop
// waveforms on tick boundaries. Each data or acknowledge bit takes four
// ticks (two with SCL low, two with SCL released). SDA is captured as
// SCL is pulled low at the end of each bit.
// Assumes tick never fires while a slave holds SCL low.
module i2c_bus_seq
    import i2c_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              go,
    input  op_e               go_op,
    input  logic [BYTE_W-1:0] go_byte,
    input  logic              go_ack,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic              scl_oe,
    output logic [BYTE_W-1:0] shreg,
    output logic              ack_seen,
    output logic              bus_held,
    output logic              byte_done,
    output logic              byte_strobe,
    output logic              idle
);
    localparam logic [BIT_CW-1:0] ACK_IDX = BIT_CW'(BYTE_W);

    sq_e               state;
    logic [2:0]        step;
    logic [BIT_CW-1:0] bitn;
    logic              is_rx;
    logic              ack_lvl;

    assign idle = (state == SQ_IDLE);

    // Command load and per-tick waveform stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SQ_IDLE;
            step        <= '0;
            bitn        <= '0;
            is_rx       <= 1'b0;
            ack_lvl     <= 1'b0;
            shreg       <= '0;
            ack_seen    <= 1'b0;
            bus_held    <= 1'b0;
            byte_done   <= 1'b0;
            byte_strobe <= 1'b0;
            sda_oe      <= 1'b0;
            scl_oe      <= 1'b0;
        end else begin
            byte_strobe <= 1'b0;
            if (go) begin
                byte_done <= 1'b0;
                step      <= '0;
                bitn      <= '0;
                is_rx     <= (go_op == OP_RECV);
                ack_lvl   <= go_ack;
                unique case (go_op)
                    OP_START: begin state <= SQ_START; shreg <= go_byte; end
                    OP_SEND:  begin state <= SQ_BITS;  shreg <= go_byte; end
                    OP_RECV:  begin state <= SQ_BITS;  shreg <= '1; end
                    OP_STOP:  state <= bus_held ? SQ_STOP : SQ_IDLE;
                endcase
            end else if (tick) begin
                unique case (state)
                    SQ_START: begin
                        step <= step + 1'b1;
                        case (step)
                            3'd0: sda_oe <= 1'b0;
                            3'd1: scl_oe <= 1'b0;
                            3'd2: begin sda_oe <= 1'b1; bus_held <= 1'b1; end
                            3'd4: begin
                                scl_oe <= 1'b1;
                                state  <= SQ_BITS;
                                step   <= '0;
                            end
                            default: ;
                        endcase
                    end
                    SQ_BITS: begin
                        step <= step + 1'b1;
                        case (step)
                            3'd0: sda_oe <= (bitn == ACK_IDX) ? (is_rx && !ack_lvl)
                                                              : !shreg[BYTE_W-1];
                            3'd1: scl_oe <= 1'b0;
                            3'd3: begin
                                scl_oe <= 1'b1;
                                step   <= '0;
                                if (bitn == ACK_IDX) begin
                                    ack_seen    <= sda_in;
                                    byte_done   <= 1'b1;
                                    byte_strobe <= 1'b1;
                                    state       <= SQ_IDLE;
                                end else begin
                                    shreg <= {shreg[BYTE_W-2:0], sda_in};
                                    bitn  <= bitn + 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end
                    SQ_STOP: begin
                        step <= step + 1'b1;
                        case (step)
                            3'd0: sda_oe <= 1'b1;
                            3'd1: scl_oe <= 1'b0;
                            3'd3: begin
                                sda_oe   <= 1'b0;
                                bus_held <= 1'b0;
                                state    <= SQ_IDLE;
                            end
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

    p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_strobe |=> !byte_strobe);

    p_strobe_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_strobe |-> byte_done);

    p_claim_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_held) |-> (sda_oe && !scl_oe));

    p_free_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_held) |-> (!sda_oe && !scl_oe));

    p_sda_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && !$stable(sda_oe))
            |-> ($past(state) == SQ_START || $past(state) == SQ_STOP));

    p_reset_release_r11: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && !scl_oe && !bus_held));

endmodule

// File: rtl/i2c_cmd_master.sv
// Top of the byte-command I2C master. Joins the handshake, the tick
// divider and the bus sequencer. The divider restarts on each accepted
// command and is held while a slave stretches SCL.
// Assumes sda_in/scl_in reflect the wired-AND bus levels.
module i2c_cmd_master
    import i2c_cmd_pkg::*;
#(
    parameter int DIVISOR = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        exec_req,
    input  logic        cmd_start,
    input  logic        cmd_send,
    input  logic        cmd_recv,
    input  logic        cmd_stop,
    input  logic [7:0]  wr_byte,
    input  logic        ack_out,
    output logic [7:0]  rd_byte,
    output logic        ack_seen,
    output logic        bus_held,
    output logic        byte_done,
    output logic        byte_strobe,
    output logic        busy,
    output logic        sda_oe,
    input  logic        sda_in,
    output logic        scl_oe,
    input  logic        scl_in
);
    logic go;
    op_e  go_op;
    logic seq_idle;
    logic tick;
    logic stretch;
    logic tick_clr;

    // A released SCL that still reads low is a slave stretch.
    assign stretch  = !scl_oe && !scl_in;
    assign tick_clr = go || stretch;

    i2c_cmd_accept u_accept (
        .clk      (clk),
        .rst_n    (rst_n),
        .exec_req (exec_req),
        .cmd_start(cmd_start),
        .cmd_send (cmd_send),
        .cmd_recv (cmd_recv),
        .cmd_stop (cmd_stop),
        .seq_idle (seq_idle),
        .busy     (busy),
        .go       (go),
        .go_op    (go_op)
    );

    i2c_tick_gen #(.DIVISOR(DIVISOR)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (tick_en),
        .clr  (tick_clr),
        .tick (tick)
    );

    i2c_bus_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .go         (go),
        .go_op      (go_op),
        .go_byte    (wr_byte),
        .go_ack     (ack_out),
        .sda_in     (sda_in),
        .sda_oe     (sda_oe),
        .scl_oe     (scl_oe),
        .shreg      (rd_byte),
        .ack_seen   (ack_seen),
        .bus_held   (bus_held),
        .byte_done  (byte_done),
        .byte_strobe(byte_strobe),
        .idle       (seq_idle)
    );

    p_no_tick_in_stretch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !scl_in) |-> !tick);

endmodule

// File: tb/tb_i2c_cmd_master.sv
// Scoreboard bench: the driver task queues expected bus events and a
// slave/monitor process compares observed events against the queue.
module tb_i2c_cmd_master;
    localparam int DIV = 25;
    localparam int K_START = 1, K_RSTART = 2, K_BYTE = 3, K_STOP = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, tick_en = 1'b1, exec_req = 1'b0;
    logic cmd_start = 1'b0, cmd_send = 1'b0, cmd_recv = 1'b0, cmd_stop = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic ack_out = 1'b0;
    logic [7:0] rd_byte;
    logic ack_seen, bus_held, byte_done, byte_strobe, busy;
    logic sda_oe, scl_oe, sda_in, scl_in;
    logic slave_sda_low = 1'b0, slave_scl_low = 1'b0;

    assign sda_in = ~(sda_oe | slave_sda_low);
    assign scl_in = ~(scl_oe | slave_scl_low);

    i2c_cmd_master #(.DIVISOR(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .exec_req(exec_req),
        .cmd_start(cmd_start), .cmd_send(cmd_send), .cmd_recv(cmd_recv),
        .cmd_stop(cmd_stop), .wr_byte(wr_byte), .ack_out(ack_out),
        .rd_byte(rd_byte), .ack_seen(ack_seen), .bus_held(bus_held),
        .byte_done(byte_done), .byte_strobe(byte_strobe), .busy(busy),
        .sda_oe(sda_oe), .sda_in(sda_in), .scl_oe(scl_oe), .scl_in(scl_in)
    );

    typedef struct { int kind; int data; int ack; } ev_t;
    ev_t exp_q[$];

    int n_chk = 0, n_bad = 0;
    int en_div = 1;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input longint act, input longint lo, input longint hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    // Enable pattern for the tick divider (R10).
    always @(negedge clk) begin
        if (en_div == 1) tick_en = 1'b1;
        else tick_en = ~tick_en;
    end

    // Slave model and bus monitor.
    logic mon_on = 1'b0, in_frame = 1'b0, slave_tx = 1'b0, slave_ack_low = 1'b1;
    logic prev_s = 1'b1, prev_d = 1'b1;
    logic [7:0] mshift = 8'h00, tx_byte = 8'h00;
    int bitidx = -1, stretch_req = 0, stretch_left = 0, strobe_cnt = 0;
    int hi_cnt = 0, lo_cnt = 0, last_hi = 0, last_lo = 0;

    task automatic report(input int kind, input int data, input int ack);
        ev_t e;
        if (!mon_on) return;
        if (exp_q.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R1 unexpected bus event actual=%0d expected=none", kind);
        end else begin
            e = exp_q.pop_front();
            chk("R1 bus event kind", kind, e.kind);
            if (kind == K_BYTE) begin
                chk("R6 byte seen on bus", data, e.data);
                chk("R8 acknowledge slot level", ack, e.ack);
            end
        end
    endtask

    always @(negedge clk) begin
        logic s, d;
        s = scl_in;
        d = sda_in;
        if (byte_strobe) strobe_cnt++;
        if (s && prev_s && prev_d && !d) begin
            report(in_frame ? K_RSTART : K_START, 0, 0);
            in_frame = 1'b1; bitidx = -1;
        end else if (s && prev_s && !prev_d && d) begin
            report(K_STOP, 0, 0);
            in_frame = 1'b0; bitidx = -1;
        end
        if (prev_s && !s && in_frame) begin
            bitidx = (bitidx >= 8) ? 0 : bitidx + 1;
            if (bitidx == 8 && stretch_req > 0) begin
                slave_scl_low = 1'b1;
                stretch_left = stretch_req;
                stretch_req = 0;
            end
        end
        if (!prev_s && s && in_frame && bitidx >= 0) begin
            if (bitidx < 8) mshift = {mshift[6:0], d};
            else begin
                report(K_BYTE, mshift, d);
                if (slave_tx && d) slave_tx = 1'b0;
            end
        end
        if (!s) begin
            if (in_frame && slave_tx && bitidx >= 0 && bitidx < 8)
                slave_sda_low = ~tx_byte[7 - bitidx];
            else if (in_frame && !slave_tx && bitidx == 8)
                slave_sda_low = slave_ack_low;
            else
                slave_sda_low = 1'b0;
        end
        if (s != prev_s) begin
            if (s) begin last_lo = lo_cnt; hi_cnt = 1; end
            else begin last_hi = hi_cnt; lo_cnt = 1; end
        end else if (s) hi_cnt++;
        else lo_cnt++;
        if (stretch_left > 0) begin
            stretch_left--;
            if (stretch_left == 0) slave_scl_low = 1'b0;
        end
        prev_s = s;
        prev_d = d;
    end

    logic model_held = 1'b0;

    // Driver: queue expected events, run one command, check port results.
    task automatic do_cmd(input int kind, input logic [7:0] b, input logic ack_o,
                          input int hold, input bit noise);
        int s0;
        logic [7:0] exp_data;
        int exp_ack;
        while (busy) @(negedge clk);
        exp_data = (kind == K_BYTE + 10) ? tx_byte : b;
        exp_ack = slave_ack_low ? 0 : 1;
        case (kind)
            1: begin
                exp_q.push_back('{model_held ? K_RSTART : K_START, 0, 0});
                model_held = 1'b1;
                exp_q.push_back('{K_BYTE, b, exp_ack});
            end
            2: exp_q.push_back('{K_BYTE, b, exp_ack});
            3: begin
                exp_data = tx_byte;
                exp_ack = ack_o;
                exp_q.push_back('{K_BYTE, tx_byte, ack_o});
            end
            default: begin
                if (model_held) exp_q.push_back('{K_STOP, 0, 0});
                model_held = 1'b0;
            end
        endcase
        s0 = strobe_cnt;
        @(negedge clk);
        cmd_start = (kind == 1); cmd_send = (kind == 2);
        cmd_recv = (kind == 3); cmd_stop = (kind == 4);
        wr_byte = b; ack_out = ack_o; exec_req = 1'b1;
        @(negedge clk);
        chk("R2 busy after accept", busy, 1);
        chk("R7 byte_done cleared on accept", byte_done, 0);
        if (hold == 0) begin
            exec_req = 1'b0;
            cmd_start = 0; cmd_send = 0; cmd_recv = 0; cmd_stop = 0;
        end
        if (noise) begin
            repeat (300) @(negedge clk);
            exec_req = 1'b1; cmd_stop = 1'b1; wr_byte = ~b;
            repeat (3) @(negedge clk);
            chk("R2 busy while request ignored", busy, 1);
            exec_req = 1'b0; cmd_stop = 1'b0;
        end
        if (hold > 0) begin
            while (strobe_cnt == s0) @(negedge clk);
            repeat (hold) @(negedge clk);
            chk("R3 busy held by request", busy, 1);
            exec_req = 1'b0;
            cmd_start = 0; cmd_send = 0; cmd_recv = 0; cmd_stop = 0;
            @(negedge clk);
            chk("R3 busy falls after request low", busy, 0);
        end
        while (busy) @(negedge clk);
        chk("R3 busy low after finish", busy, 0);
        if (kind != 4) begin
            chk("R6 rd_byte", rd_byte, exp_data);
            chk("R8 ack_seen", ack_seen, exp_ack);
            chk("R7 byte_done set", byte_done, 1);
            chk("R7 strobe count", strobe_cnt - s0, 1);
        end else begin
            chk("R7 no strobe on stop", strobe_cnt - s0, 0);
        end
        chk("R5 bus_held", bus_held, model_held);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset sda released", sda_oe, 0);
        chk("R11 reset scl released", scl_oe, 0);
        chk("R11 reset busy", busy, 0);
        chk("R11 reset bus_held", bus_held, 0);
        chk("R11 reset byte_done", byte_done, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        mon_on = 1'b1;

        // R1/R3: start with address, request held past completion.
        slave_ack_low = 1'b1;
        do_cmd(1, 8'hA4, 1'b0, 40, 1'b0);
        chk_rng("R10 SCL high phase", last_hi, 2*DIV-3, 2*DIV+3);
        // R2: send with ignored requests while busy.
        do_cmd(2, 8'h5B, 1'b0, 0, 1'b1);
        // R8: slave refuses.
        slave_ack_low = 1'b0;
        do_cmd(2, 8'h96, 1'b0, 0, 1'b0);
        // R4: start while held gives repeated start.
        slave_ack_low = 1'b1;
        do_cmd(1, 8'hA5, 1'b0, 0, 1'b0);
        // R6/R8: two reads, acknowledged then refused.
        tx_byte = 8'h3C; slave_tx = 1'b1;
        do_cmd(3, 8'h00, 1'b0, 0, 1'b0);
        tx_byte = 8'hC3;
        do_cmd(3, 8'h00, 1'b1, 0, 1'b0);
        chk("R8 slave released after refusal", slave_tx, 0);
        // R9: stretch the acknowledge slot.
        stretch_req = 200;
        do_cmd(2, 8'h71, 1'b0, 0, 1'b0);
        chk_rng("R9 stretched low phase", last_lo, 199, 202);
        chk_rng("R9 high phase after stretch", last_hi, 2*DIV-3, 2*DIV+3);
        // R10: half-rate tick enable.
        en_div = 2;
        do_cmd(2, 8'h2E, 1'b0, 0, 1'b0);
        chk_rng("R10 SCL high phase at half enable", last_hi, 4*DIV-4, 4*DIV+4);
        en_div = 1;
        // R5: stop, then stop on a free bus.
        do_cmd(4, 8'h00, 1'b0, 0, 1'b0);
        chk("R5 lines idle after stop", {sda_in, scl_in}, 2'b11);
        do_cmd(4, 8'h00, 1'b0, 0, 1'b0);
        repeat (200) @(negedge clk);
        chk("R5 lines idle after free stop", {sda_in, scl_in}, 2'b11);
        chk("R1 all expected events seen", exp_q.size(), 0);

        // R11: reset in the middle of a transfer.
        mon_on = 1'b0;
        @(negedge clk);
        cmd_start = 1'b1; wr_byte = 8'h18; exec_req = 1'b1;
        @(negedge clk);
        exec_req = 1'b0; cmd_start = 1'b0;
        repeat (400) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 mid reset sda released", sda_oe, 0);
        chk("R11 mid reset scl released", scl_oe, 0);
        chk("R11 mid reset busy", busy, 0);
        chk("R11 mid reset bus_held", bus_held, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R12 bus idle high after reset", {sda_in, scl_in}, 2'b11);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule